// File: doc/BRIEF.md
# Receive Byte Buffer with Trigger and Idle-Line Interrupts

This block sits between a serial receiver's shift register and a processor read port. Each byte the receiver completes is written into a 16-entry first-in first-out store. The processor pops bytes one at a time. The head byte is always visible on the read data output before the pop. The current occupancy is reported on a count output.

Two interrupt outputs tell the processor when to service the buffer. The first asserts once the occupancy reaches a level chosen by a 2-bit select. The second covers a short final burst that never reaches that level. It fires when bytes are waiting and four character times have passed with neither a pop nor a new arrival. A byte that arrives while the store is full is discarded, and a sticky overrun flag is raised. That flag clears only on a dedicated clear strobe, which stands in for a status read.

Occupancy is tracked by a three-state machine: EMPTY, PARTIAL and FULL. The transitions are:
- EMPTY to PARTIAL on an accepted write.
- PARTIAL to FULL on a write alone at 15 bytes.
- PARTIAL to EMPTY on a pop alone at 1 byte.
- FULL to PARTIAL on a pop alone.

The idle timer is a second machine with states IDLE, WAIT and FIRED. The transitions are:
- Any access moves it to WAIT if bytes remain afterwards, and to IDLE otherwise.
- In WAIT, the fourth character tick moves it to FIRED.
- FIRED is held until the next access.

Top module: `rx_fifo_timeout`

## Requirements
- R1: After reset the count is 0 and the overrun flag and both interrupts are low. Up to 16 bytes are stored, and they are popped in arrival order, with the head byte shown on the read data output before the pop.
- R2: The select code maps to a trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. The data interrupt is high whenever the count is at or above that level. It drops in the same cycle the count falls below it.
- R3: A byte arriving while 16 bytes are stored, with no pop in that cycle, is not stored. The count and the stored contents are unchanged.
- R4: Such a dropped byte sets the overrun flag on the following clock edge. The flag stays set until a clear strobe arrives. If a set and a clear occur in the same cycle, the set wins.
- R5: A pop and an arrival in the same cycle while full both complete. The count stays 16 and no overrun is flagged.
- R6: A pop while empty is ignored. The count stays 0, and the next stored byte is read back intact.
- R7: The timeout interrupt rises on the clock edge of the fourth character tick counted since the last access, provided at least one byte is stored. It never asserts while the buffer is empty.
- R8: A pop or an accepted arrival clears the timeout interrupt on the next edge and restarts the tick count from zero. A tick in the same cycle as an access is not counted.
- R9: Both interrupt outputs are low while the interrupt enable is low. The enable does not alter the stored data, the count or the timer progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| rd_en | input | 1 | One-cycle processor pop strobe |
| rd_data | output | 8 | Head byte of the buffer |
| trig_sel | input | 2 | Trigger level select (0:1, 1:4, 2:8, 3:14) |
| rx_irq_en | input | 1 | Receive interrupt enable |
| char_tick | input | 1 | One-cycle pulse per elapsed character time |
| ovr_clr | input | 1 | Clears the overrun flag |
| level | output | 5 | Number of stored bytes |
| overrun | output | 1 | Sticky overrun flag |
| data_irq | output | 1 | Trigger-level interrupt |
| timeout_irq | output | 1 | Idle-line timeout interrupt |

## Verification
The embedded properties check several rules on every cycle:
- the count never exceeds the depth, and it agrees with the occupancy state;
- a blocked arrival leaves the write pointer unchanged and sets the overrun flag;
- a full-buffer pop and arrival together keep the count at 16;
- an empty pop leaves the count at zero;
- any access removes the timeout, the timeout never fires while empty, and it only fires on a tick.

The directed scenarios are needed for the rest:
- arrival ordering and byte integrity across a dropped byte;
- the exact threshold of each trigger code;
- precedence of a set over a clear on the overrun flag;
- the precise tick count, including a tick that coincides with an access;
- gating by the enable without loss of timer state.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    typedef enum logic [1:0] {
        TMO_IDLE  = 2'd0,
        TMO_WAIT  = 2'd1,
        TMO_FIRED = 2'd2
    } tmo_state_e;

    typedef enum logic [1:0] {
        TRIG_SINGLE = 2'd0,
        TRIG_LOW    = 2'd1,
        TRIG_MID    = 2'd2,
        TRIG_HIGH   = 2'd3
    } trig_code_e;

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          wr_acc,
    output logic          rd_acc
);

    localparam logic [LW-1:0] LVL_MAX  = LW'(DEPTH);
    localparam logic [LW-1:0] LVL_LAST = LW'(DEPTH - 1);
    localparam logic [AW-1:0] PTR_END  = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    occ_state_e    occ_q, occ_d;

    assign full    = (occ_q == OCC_FULL);
    assign empty   = (occ_q == OCC_EMPTY);
    assign rd_acc  = rd_req && !empty;
    assign wr_acc  = wr_req && (!full || rd_req);
    assign rd_data = mem[rd_ptr];

    // occupancy state register
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= OCC_EMPTY;
        else        occ_q <= occ_d;
    end

    // occupancy transitions
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (wr_acc) occ_d = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (wr_acc && !rd_acc && level == LVL_LAST)
                    occ_d = OCC_FULL;
                else if (rd_acc && !wr_acc && level == LW'(1))
                    occ_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (rd_acc && !wr_acc) occ_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
            end
            default: occ_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_acc) wr_ptr <= (wr_ptr == PTR_END) ? '0 : wr_ptr + AW'(1);
            if (rd_acc) rd_ptr <= (rd_ptr == PTR_END) ? '0 : rd_ptr + AW'(1);
            if (wr_acc && !rd_acc)      level <= level + LW'(1);
            else if (rd_acc && !wr_acc) level <= level - LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_acc) mem[wr_ptr] <= wr_data;
    end

    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_MAX);

    a_r1_state_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        ((occ_q == OCC_FULL) == (level == LVL_MAX)) &&
        ((occ_q == OCC_EMPTY) == (level == '0)));

    a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_MAX && wr_req && !rd_req) |=> ($stable(wr_ptr) && level == LVL_MAX));

    a_r5_full_both: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_MAX && wr_req && rd_req) |=> level == LVL_MAX);

    a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && rd_req && !wr_req) |=> level == '0);

endmodule

// File: rtl/rxf_trig.sv
module rxf_trig
    import rxf_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int LVL_A  = 1,
    parameter  int LVL_B  = 4,
    parameter  int LVL_C  = 8,
    parameter  int LVL_D  = 14,
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    trig_sel,
    input  logic [LW-1:0] level,
    input  logic          irq_en,
    output logic          irq
);

    logic [LW-1:0] thresh;
    trig_code_e    code;

    assign code = trig_code_e'(trig_sel);

    always_comb begin
        unique case (code)
            TRIG_SINGLE: thresh = LW'(LVL_A);
            TRIG_LOW:    thresh = LW'(LVL_B);
            TRIG_MID:    thresh = LW'(LVL_C);
            TRIG_HIGH:   thresh = LW'(LVL_D);
            default:     thresh = LW'(LVL_A);
        endcase
    end

    assign irq = irq_en && (level >= thresh);

endmodule

// File: rtl/rxf_tmo.sv
module rxf_tmo
    import rxf_pkg::*;
#(
    parameter  int DEPTH     = 16,
    parameter  int TMO_CHARS = 4,
    localparam int LW        = $clog2(DEPTH + 1),
    localparam int CW        = $clog2(TMO_CHARS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_acc,
    input  logic          rd_acc,
    input  logic [LW-1:0] level,
    input  logic          char_tick,
    input  logic          irq_en,
    output logic          irq
);

    localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CHARS - 1);

    tmo_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          access;
    logic          fired;

    assign access = wr_acc || rd_acc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TMO_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (access) begin
            cnt_d = '0;
            st_d  = (wr_acc || level > LW'(1)) ? TMO_WAIT : TMO_IDLE;
        end else begin
            unique case (st_q)
                TMO_IDLE:  cnt_d = '0;
                TMO_WAIT: begin
                    if (char_tick) begin
                        if (cnt_q == CNT_LAST) begin
                            st_d  = TMO_FIRED;
                            cnt_d = CW'(TMO_CHARS);
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                TMO_FIRED: cnt_d = CW'(TMO_CHARS);
                default:   st_d  = TMO_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        fired = (st_q == TMO_FIRED);
        irq   = fired && irq_en;
    end

    a_r7_never_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> !fired);

    a_r7_fires_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fired) |-> ($past(char_tick) && $past(cnt_q) == CNT_LAST));

    a_r8_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> (!fired && cnt_q == '0));

endmodule

// File: rtl/rx_fifo_timeout.sv
module rx_fifo_timeout
    import rxf_pkg::*;
#(
    parameter  int DEPTH     = 16,
    parameter  int DW        = 8,
    parameter  int TMO_CHARS = 4,
    parameter  int LVL_A     = 1,
    parameter  int LVL_B     = 4,
    parameter  int LVL_C     = 8,
    parameter  int LVL_D     = 14,
    localparam int LW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic [1:0]    trig_sel,
    input  logic          rx_irq_en,
    input  logic          char_tick,
    input  logic          ovr_clr,
    output logic [LW-1:0] level,
    output logic          overrun,
    output logic          data_irq,
    output logic          timeout_irq
);

    logic full, empty, wr_acc, rd_acc, drop;

    rxf_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (rx_valid),
        .wr_data (rx_data),
        .rd_req  (rd_en),
        .rd_data (rd_data),
        .level   (level),
        .full    (full),
        .empty   (empty),
        .wr_acc  (wr_acc),
        .rd_acc  (rd_acc)
    );

    rxf_trig #(
        .DEPTH(DEPTH), .LVL_A(LVL_A), .LVL_B(LVL_B), .LVL_C(LVL_C), .LVL_D(LVL_D)
    ) trig_i (
        .trig_sel (trig_sel),
        .level    (level),
        .irq_en   (rx_irq_en),
        .irq      (data_irq)
    );

    rxf_tmo #(.DEPTH(DEPTH), .TMO_CHARS(TMO_CHARS)) tmo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_acc    (wr_acc),
        .rd_acc    (rd_acc),
        .level     (level),
        .char_tick (char_tick),
        .irq_en    (rx_irq_en),
        .irq       (timeout_irq)
    );

    assign drop = rx_valid && !wr_acc;

    always_ff @(posedge clk) begin
        if (!rst_n)       overrun <= 1'b0;
        else if (drop)    overrun <= 1'b1;
        else if (ovr_clr) overrun <= 1'b0;
    end

    a_r4_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rx_valid && !rd_en) |=> overrun);

    a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    a_r5_no_false_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (!overrun && full && rx_valid && rd_en) |=> !overrun);

    a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq_en |-> (!data_irq && !timeout_irq));

endmodule

// File: tb/rx_fifo_timeout_tb_top.sv
`timescale 1ns/1ps
module rx_fifo_timeout_tb_top;

    logic       clk, rst_n;
    logic       rx_valid, rd_en, rx_irq_en, char_tick, ovr_clr;
    logic [7:0] rx_data, rd_data;
    logic [1:0] trig_sel;
    logic [4:0] level;
    logic       overrun, data_irq, timeout_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    rx_fifo_timeout dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_en(rd_en), .rd_data(rd_data), .trig_sel(trig_sel),
        .rx_irq_en(rx_irq_en), .char_tick(char_tick), .ovr_clr(ovr_clr),
        .level(level), .overrun(overrun), .data_irq(data_irq),
        .timeout_irq(timeout_irq)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_data  = b;
        cyc();
        rx_valid = 1'b0;
    endtask

    task automatic pop(output logic [7:0] b);
        b     = rd_data;
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic tick();
        char_tick = 1'b1;
        cyc();
        char_tick = 1'b0;
    endtask

    task automatic drain();
        logic [7:0] b;
        while (level != 0) pop(b);
    endtask

    task automatic t_reset();
        chk("R1 reset level", level, 0);
        chk("R1 reset overrun", overrun, 0);
        chk("R1 reset data_irq", data_irq, 0);
        chk("R1 reset timeout_irq", timeout_irq, 0);
    endtask

    task automatic t_order();
        logic [7:0] b;
        push(8'hA1); push(8'hA2); push(8'hA3);
        chk("R1 level after 3", level, 3);
        pop(b); chk("R1 order 0", b, 8'hA1);
        pop(b); chk("R1 order 1", b, 8'hA2);
        pop(b); chk("R1 order 2", b, 8'hA3);
        chk("R1 level drained", level, 0);
    endtask

    task automatic t_trigger();
        logic [7:0] b;
        int tl [4] = '{1, 4, 8, 14};
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            for (int k = 1; k < tl[s]; k++) push(8'(k));
            #1 chk("R2 below trigger", data_irq, 0);
            push(8'h77);
            chk("R2 at trigger", data_irq, 1);
            rx_irq_en = 1'b0;
            #1 chk("R9 data_irq gated", data_irq, 0);
            rx_irq_en = 1'b1;
            #1;
            pop(b);
            chk("R2 drop below trigger", data_irq, 0);
            drain();
        end
        trig_sel = 2'd3;
    endtask

    task automatic t_full();
        logic [7:0] b;
        for (int i = 0; i < 16; i++) push(8'(i + 16));
        chk("R1 level full", level, 16);
        chk("R4 no overrun yet", overrun, 0);
        push(8'hEE);
        chk("R3 level held", level, 16);
        chk("R4 overrun set", overrun, 1);
        cyc();
        chk("R4 overrun sticky", overrun, 1);
        ovr_clr = 1'b1; cyc(); ovr_clr = 1'b0;
        chk("R4 overrun cleared", overrun, 0);
        ovr_clr = 1'b1; push(8'hEF); ovr_clr = 1'b0;
        chk("R4 set beats clear", overrun, 1);
        ovr_clr = 1'b1; cyc(); ovr_clr = 1'b0;
        for (int i = 0; i < 16; i++) begin
            pop(b);
            chk("R3 contents kept", b, i + 16);
        end
        chk("R3 empty after drain", level, 0);
    endtask

    task automatic t_simul();
        logic [7:0] b;
        for (int i = 0; i < 16; i++) push(8'(i + 64));
        b = rd_data;
        rx_valid = 1'b1; rx_data = 8'hC3; rd_en = 1'b1;
        cyc();
        rx_valid = 1'b0; rd_en = 1'b0;
        chk("R5 head popped", b, 64);
        chk("R5 level stays full", level, 16);
        chk("R5 no overrun", overrun, 0);
        for (int i = 1; i < 16; i++) begin
            pop(b);
            chk("R5 order kept", b, i + 64);
        end
        pop(b);
        chk("R5 new byte last", b, 8'hC3);
    endtask

    task automatic t_empty_read();
        logic [7:0] b;
        rd_en = 1'b1; cyc(); rd_en = 1'b0;
        chk("R6 level after empty pop", level, 0);
        push(8'h5A);
        chk("R6 level one", level, 1);
        pop(b);
        chk("R6 byte intact", b, 8'h5A);
    endtask

    task automatic t_timeout();
        logic [7:0] b;
        repeat (5) tick();
        chk("R7 no timeout when empty", timeout_irq, 0);
        push(8'h11);
        repeat (3) tick();
        chk("R7 three ticks", timeout_irq, 0);
        tick();
        chk("R7 fourth tick", timeout_irq, 1);
        repeat (3) cyc();
        chk("R7 held", timeout_irq, 1);
        rx_irq_en = 1'b0;
        tick();
        chk("R9 timeout gated", timeout_irq, 0);
        chk("R9 level kept", level, 1);
        rx_irq_en = 1'b1;
        #1 chk("R9 timeout restored", timeout_irq, 1);
        pop(b);
        chk("R8 read clears", timeout_irq, 0);
        push(8'h22);
        repeat (3) tick();
        push(8'h33);
        chk("R8 arrival clears", timeout_irq, 0);
        repeat (3) tick();
        chk("R8 restarted count", timeout_irq, 0);
        tick();
        chk("R8 fires after restart", timeout_irq, 1);
        push(8'h44);
        chk("R8 arrival clears fired", timeout_irq, 0);
        char_tick = 1'b1; push(8'h55); char_tick = 1'b0;
        repeat (3) tick();
        chk("R8 tick with access ignored", timeout_irq, 0);
        tick();
        chk("R8 fires on fourth real tick", timeout_irq, 1);
        pop(b);
        chk("R8 partial read clears", timeout_irq, 0);
        repeat (4) tick();
        chk("R7 refires with bytes left", timeout_irq, 1);
        drain();
        chk("R7 clear after drain", timeout_irq, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_valid = 1'b0; rd_en = 1'b0; rx_data = '0;
        trig_sel = 2'd3; rx_irq_en = 1'b1; char_tick = 1'b0; ovr_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_order();
        t_trigger();
        t_full();
        t_simul();
        t_empty_read();
        t_timeout();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule